// File: doc/BRIEF.md
# Per-Pin Debounced Edge Wakeup Detector

This block watches an input port and raises a wakeup request when a selected edge appears on any pin that software has enabled. Each pin has its own 4-bit setting. Two bits pick how long the pin must hold a new level before that level is accepted. The other two bits pick whether a rising edge, a falling edge, both or neither counts as a wakeup event.

Each pin goes through three stages. A two-flop synchronizer comes first. A stability filter follows, and it accepts a new level only after that level has been seen on a run of consecutive clock cycles. Last comes an edge detector that adds two registered cycles. The per-pin events are merged into a single one-cycle wakeup pulse. A sticky per-pin source register records which pins caused a wakeup until those bits are cleared.

Top module: `pin_wake_detect`

## Requirements
- R1: With filter code 00, the filter output follows the synchronized pin after one cycle. A pin change driven before rising edge 1 produces `wake` high after rising edge 5.
- R2: Filter codes 01, 10 and 11 need 2, 4 and 8 consecutive cycles at the new level. A change that lasts for fewer cycles is discarded. An accepted change driven before edge 1 shows on `wake` after edge 4+N, where N is the required count (12 for code 11).
- R3: If the synchronized pin returns to the accepted level before the count completes, the stability count starts again from zero.
- R4: The edge code selects the trigger: 00 means the pin never wakes, 01 means rising only, 10 means falling only, and 11 means both edges.
- R5: `wake` is high for exactly one cycle for each cycle in which one or more pins produce a qualified edge. Edges on several pins in the same cycle give a single pulse.
- R6: Bit i of `wake_src` is set in the same cycle that pin i's edge drives `wake`. It stays set until `src_clr[i]` is high at a clock edge. A set in the same cycle takes priority over a clear. A bit never rises without `wake`.
- R7: While `rst_n` is low, `wake`, `wake_src` and all filter and edge state are zero.
- R8: When the pins have been unchanged for 16 cycles, `wake` stays low.
- R9: Pin i takes its filter code from `cfg[4i+1:4i]` and its edge code from `cfg[4i+3:4i+2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter and detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | PINS | Raw, asynchronous port pins |
| cfg | input | 4*PINS | Per-pin filter and edge codes, 4 bits per pin |
| src_clr | input | PINS | Per-pin clear of the sticky source bits |
| wake | output | 1 | One-cycle combined wakeup pulse |
| wake_src | output | PINS | Sticky record of the pins that woke the block |

## Verification
The bench measures exact latency at the fastest and slowest filter settings. A stage too many or too few moves the first `wake` by a cycle and fails the check. Pulses one cycle shorter than the required count must be filtered out, and pulses of exactly the required count must pass, so an off-by-one in the count compare shows up on one side or the other. A broken pulse made of two runs that are each too short must give no wakeup; a filter that kept counting through the break would accept it. Simultaneous edges on two pins must give one pulse and two source bits, and clearing one bit must leave the other set, which exposes a merged pulse that is too long or a clear applied to the wrong bits.

// File: rtl/pin_wake_detect.sv
module pin_wake_detect #(
  parameter int PINS  = 8,
  parameter int CNT_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PINS-1:0]   pin_in,
  input  logic [4*PINS-1:0] cfg,
  input  logic [PINS-1:0]   src_clr,
  output logic              wake,
  output logic [PINS-1:0]   wake_src
);
  logic [PINS-1:0] sync1, sync2, filt, filt_d, hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic [1:0]       deb_code, edge_code;
    logic [CNT_W-1:0] cnt, limit;
    logic             rise, fall;

    assign deb_code  = cfg[4*i +: 2];
    assign edge_code = cfg[4*i+2 +: 2];
    assign limit     = (CNT_W'(1) << deb_code) - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        filt[i] <= 1'b0;
        cnt     <= '0;
      end else if (sync2[i] == filt[i]) begin
        cnt <= '0;
      end else if (cnt >= limit) begin
        filt[i] <= sync2[i];
        cnt     <= '0;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end

    assign rise = filt[i] & ~filt_d[i];
    assign fall = ~filt[i] & filt_d[i];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        filt_d[i] <= 1'b0;
        hit[i]    <= 1'b0;
      end else begin
        filt_d[i] <= filt[i];
        hit[i]    <= (edge_code[0] & rise) | (edge_code[1] & fall);
      end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wake     <= 1'b0;
      wake_src <= '0;
    end else begin
      wake     <= |hit;
      wake_src <= (wake_src & ~src_clr) | hit;
    end
endmodule

// File: rtl/pin_wake_detect_chk.sv
module pin_wake_detect_chk #(
  parameter int PINS = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PINS-1:0]   pin_in,
  input logic [4*PINS-1:0] cfg,
  input logic [PINS-1:0]   src_clr,
  input logic              wake,
  input logic [PINS-1:0]   wake_src
);
  logic [1:0]      age;
  logic [4:0]      still;
  logic [PINS-1:0] pin_q;
  logic            all_off;

  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < PINS; i++)
      if (cfg[4*i+2 +: 2] != 2'b00) all_off = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      age   <= '0;
      still <= '0;
      pin_q <= '0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      pin_q <= pin_in;
      if (pin_in != pin_q) still <= '0;
      else if (still != 5'd31) still <= still + 5'd1;
    end

  p_wake_has_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> (wake_src != '0));

  p_src_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> (($past(wake_src) & ~$past(src_clr) & ~wake_src) == '0));

  p_src_needs_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1) |-> (((wake_src & ~$past(wake_src)) == '0) || wake));

  p_all_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && all_off && $past(all_off) && $past(all_off, 2)) |-> !wake);

  p_quiet_when_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (still >= 5'd16) |-> !wake);

  always @(posedge clk)
    if (!rst_n) p_reset_clear_r7: assert (wake == 1'b0 || $isunknown(wake));
endmodule

bind pin_wake_detect pin_wake_detect_chk #(.PINS(PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg(cfg),
  .src_clr(src_clr), .wake(wake), .wake_src(wake_src)
);

// File: tb/pin_wake_detect_tb.sv
module pin_wake_detect_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pin_in = '0;
  logic [31:0] cfg = '0;
  logic [7:0]  src_clr = '0;
  logic        wake;
  logic [7:0]  wake_src;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pin_wake_detect #(.PINS(8), .CNT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cfg(cfg),
    .src_clr(src_clr), .wake(wake), .wake_src(wake_src)
  );

  // {pin[2:0], deb[1:0], edge[1:0], width[4:0], expected pulses[1:0]}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    {3'd0, 2'd0, 2'b01, 5'd1, 2'd1},
    {3'd1, 2'd0, 2'b10, 5'd3, 2'd1},
    {3'd2, 2'd0, 2'b11, 5'd2, 2'd2},
    {3'd3, 2'd0, 2'b00, 5'd4, 2'd0},
    {3'd4, 2'd1, 2'b11, 5'd1, 2'd0},
    {3'd4, 2'd1, 2'b11, 5'd2, 2'd2},
    {3'd5, 2'd2, 2'b01, 5'd3, 2'd0},
    {3'd5, 2'd2, 2'b01, 5'd4, 2'd1},
    {3'd6, 2'd3, 2'b11, 5'd7, 2'd0},
    {3'd7, 2'd3, 2'b11, 5'd8, 2'd2},
    {3'd7, 2'd3, 2'b10, 5'd9, 2'd1}
  };

  int seen;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (wake) seen++;
  endtask

  task automatic clear_src();
    src_clr = 8'hFF;
    step();
    src_clr = '0;
  endtask

  task automatic pulse(input int pin, input int width);
    pin_in[pin] = 1'b1;
    repeat (width) step();
    pin_in[pin] = 1'b0;
    repeat (24) step();
  endtask

  task automatic latency(input int pin, output int first);
    first = -1;
    pin_in[pin] = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      step();
      if (wake && first < 0) first = k;
    end
    pin_in[pin] = 1'b0;
    repeat (24) step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int first;
    seen = 0;
    repeat (3) @(negedge clk);
    check(wake == 1'b0, "R7 wake in reset", int'(wake), 0);
    check(wake_src == '0, "R7 src in reset", int'(wake_src), 0);
    rst_n = 1'b1;
    repeat (4) step();

    // R9 pin placement of cfg fields, R4 edge codes, R2 counts
    for (int v = 0; v < NV; v++) begin
      int pin, deb, edg, w, exp;
      {pin, deb, edg, w, exp} = {29'd0, VEC[v][13:11], 30'd0, VEC[v][10:9],
                                 30'd0, VEC[v][8:7], 27'd0, VEC[v][6:2], 30'd0, VEC[v][1:0]};
      cfg = '0;
      cfg[4*pin +: 4] = 4'(edg << 2 | deb);
      clear_src();
      seen = 0;
      pulse(pin, w);
      check(seen == exp, "R2/R4/R9 pulse count", seen, exp);
      check(wake_src == ((exp > 0) ? 8'(1 << pin) : 8'h00), "R6/R9 source bit",
            int'(wake_src), (exp > 0) ? (1 << pin) : 0);
    end

    // R1 bypass latency
    cfg = '0; cfg[3:0] = 4'b0100;
    clear_src();
    latency(0, first);
    check(first == 5, "R1 bypass latency", first, 5);

    // R2 slowest filter latency
    cfg = '0; cfg[7:4] = 4'b0111;
    latency(1, first);
    check(first == 12, "R2 eight-cycle latency", first, 12);

    // R3 an interrupted run restarts the count
    cfg = '0; cfg[3:0] = 4'b0110;
    clear_src();
    seen = 0;
    pin_in[0] = 1'b1; repeat (3) step();
    pin_in[0] = 1'b0; step();
    pin_in[0] = 1'b1; repeat (3) step();
    pin_in[0] = 1'b0; repeat (24) step();
    check(seen == 0, "R3 broken run rejected", seen, 0);
    pulse(0, 4);
    check(seen == 1, "R3 full run accepted", seen, 1);

    // R5 simultaneous edges merge into one pulse
    cfg = '0; cfg[7:4] = 4'b0100; cfg[11:8] = 4'b0100;
    clear_src();
    seen = 0;
    pin_in[2:1] = 2'b11;
    repeat (10) step();
    check(seen == 1, "R5 merged pulse", seen, 1);
    check(wake_src == 8'h06, "R5 both sources", int'(wake_src), 6);
    pin_in[2:1] = 2'b00;
    repeat (30) step();

    // R6 sticky until cleared, per bit
    check(wake_src == 8'h06, "R6 sticky", int'(wake_src), 6);
    src_clr = 8'h02; step(); src_clr = '0; step();
    check(wake_src == 8'h04, "R6 per-bit clear", int'(wake_src), 4);

    // R8 stable pins give no wakeup
    seen = 0;
    repeat (40) step();
    check(seen == 0, "R8 quiet", seen, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule